// File: doc/BRIEF.md
# Dual-Bank Pin Controller with Set/Clear Registers

This block controls 32 general-purpose pins, organised as two banks of 16. Each pin has six configuration bits: drive level, drive enable, input-buffer enable, two output alternate-function selects and one input alternate-function select. Software reaches them through a small synchronous register bus that has an address, a write strobe, 32-bit write data and combinational 32-bit read data. A feature register is never overwritten as a whole. One write carries a set mask in its lower half and a clear mask in its upper half, so two agents that share a bank never need a read-modify-write sequence.

Pad inputs are resynchronised before they are used. The controller reports the synchronised level of each pin. It also keeps one sticky status bit per pin for rising transitions and another for falling transitions. Software clears a status bit by writing a one to that pin's position. Four pins (23, 29, 30 and 31) are reserved. They can never be configured, driven or reported.

Top module: `pinctl_setclr`

## Requirements
- R1: After reset, every configuration bit and every edge-status bit is 0. As a result `pad_oe` is all zeros and every register reads 0.
- R2: Register word index w (byte offset 4·w within a bank) selects one of six feature registers: 0 drive level, 1 drive enable, 2 input enable, 3 output alt-1, 4 output alt-2, 5 input alt-1. In a write to a feature register, write-data bit n (n < 16) set to 1 sets the feature for pin n of that bank, and bit n+16 set to 1 clears it. Bits written as 0 leave the feature unchanged. The change is visible from the next clock edge.
- R3: If the set bit and the clear bit of the same pin are both 1 in one write, the feature ends at 0.
- R4: A read of a feature register returns the bank's 16 feature bits in bits 15:0 and zeros in bits 31:16. Reads are combinational from the address.
- R5: Address bit 7 selects the bank, so the second bank (pins 16–31) sits 0x80 above the first bank. Pin 16+n of the second bank maps to data bit n.
- R6: Pins 23, 29, 30 and 31 are reserved. Writes to their bits have no effect, every register reads 0 there, and `pad_out`, `pad_oe` and the select outputs for these pins stay 0.
- R7: `pad_out` equals the drive-level register and `pad_oe` equals the drive-enable register. The three alternate-select outputs and `in_buf_en` equal their feature registers.
- R8: Word index 6 (level) returns each pin's pad input in bits 15:0. The value passes through a two-flop synchronizer and is ANDed with that pin's input enable, so a pad change becomes visible two clock edges later. Writes to this word have no effect.
- R9: Word indices 7 (rising) and 8 (falling) hold sticky status bits. A status bit is set one edge after the synchronised level of an input-enabled pin changes in the matching direction. A pin whose input enable is 0 never sets a status bit.
- R10: A write to a status register clears exactly the pins whose bits 15:0 are 1. Bits 31:16 are ignored, and the write never sets a status bit.
- R11: When a new edge and a clearing write hit the same status bit on the same clock edge, the bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address: bit 7 bank, bits 5:2 word index, other bits 0 |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data (set mask low half, clear mask high half) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Pad drive level |
| pad_oe | output | 32 | Pad drive enable |
| in_buf_en | output | 32 | Input-buffer enable per pin |
| alt_out1_sel | output | 32 | Output alternate-function 1 select |
| alt_out2_sel | output | 32 | Output alternate-function 2 select |
| alt_in1_sel | output | 32 | Input alternate-function 1 select |

## Verification
Every feature bit drives a port directly. A corrupted set/clear merge, a clear-priority error or a bank-decode mistake therefore shows on `pad_out`, `pad_oe` or one of the select outputs on the very next clock. Faults in the synchronizer or the edge logic show only through reads: a wrong level appears at the second edge after a pad change, and a wrong status bit appears one edge later. For that reason the bench keeps the read address moving across level and status words. Timed directed sequences place a pad edge on the same edge as a clearing write, and they toggle pins whose input enable is off.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

   // Number of set/clear feature registers per bank
   localparam int FEAT_CNT = 6;
   // Number of decoded words per bank
   localparam int REG_CNT  = 9;

   typedef enum logic [3:0] {
      REG_DRV_LVL = 4'd0,
      REG_DRV_EN  = 4'd1,
      REG_IN_EN   = 4'd2,
      REG_OALT1   = 4'd3,
      REG_OALT2   = 4'd4,
      REG_IALT1   = 4'd5,
      REG_LEVEL   = 4'd6,
      REG_RISE    = 4'd7,
      REG_FALL    = 4'd8
   } reg_idx_e;

endpackage

// File: rtl/pinctl_feat_reg.sv
// One per-pin feature register updated from a packed set/clear command word.
module pinctl_feat_reg #(
   parameter int         W    = 16,
   parameter logic [W-1:0] KEEP = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [2*W-1:0] cmd,
   output logic [W-1:0]   q
);

   logic [W-1:0] set_m;
   logic [W-1:0] clr_m;
   logic [W-1:0] nxt;

   always_comb begin
      set_m = cmd[W-1:0];
      clr_m = cmd[2*W-1:W];
      // clear has priority over set for the same pin
      nxt   = ((q | set_m) & ~clr_m) & KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= nxt;
   end

endmodule

// File: rtl/pinctl_edge_det.sv
// Pad input synchronizer, gated level and sticky rise/fall status.
module pinctl_edge_det #(
   parameter int           W           = 16,
   parameter int           SYNC_STAGES = 2,
   parameter logic [W-1:0] KEEP        = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pad_in,
   input  logic [W-1:0] in_en,
   input  logic         clr_rise,
   input  logic         clr_fall,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] level,
   output logic [W-1:0] rise_sts,
   output logic [W-1:0] fall_sts
);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("pinctl_edge_det: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0][W-1:0] stage_q;
   logic [W-1:0] synced;
   logic [W-1:0] prev_q;
   logic [W-1:0] rise_ev;
   logic [W-1:0] fall_ev;
   logic [W-1:0] rise_keep;
   logic [W-1:0] fall_keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         prev_q  <= '0;
      end else begin
         stage_q <= {stage_q[SYNC_STAGES-2:0], pad_in};
         prev_q  <= synced;
      end
   end

   always_comb begin
      synced    = stage_q[SYNC_STAGES-1];
      level     = synced & in_en & KEEP;
      rise_ev   =  synced & ~prev_q & in_en & KEEP;
      fall_ev   = ~synced &  prev_q & in_en & KEEP;
      rise_keep = clr_rise ? ~clr_mask : '1;
      fall_keep = clr_fall ? ~clr_mask : '1;
   end

   // a fresh edge wins over a simultaneous software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_sts <= '0;
         fall_sts <= '0;
      end else begin
         rise_sts <= (rise_sts & rise_keep) | rise_ev;
         fall_sts <= (fall_sts & fall_keep) | fall_ev;
      end
   end

endmodule

// File: rtl/pinctl_bank.sv
// One bank: six feature registers, edge logic and read mux.
module pinctl_bank
   import pinctl_pkg::*;
#(
   parameter int           W           = 16,
   parameter int           SYNC_STAGES = 2,
   parameter logic [W-1:0] KEEP        = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sel,
   input  logic           we,
   input  reg_idx_e       reg_idx,
   input  logic [2*W-1:0] wdata,
   input  logic [W-1:0]   pad_in,
   output logic [W-1:0]   drv_lvl,
   output logic [W-1:0]   drv_en,
   output logic [W-1:0]   in_en,
   output logic [W-1:0]   oalt1,
   output logic [W-1:0]   oalt2,
   output logic [W-1:0]   ialt1,
   output logic [W-1:0]   rise_sts,
   output logic [W-1:0]   fall_sts,
   output logic [2*W-1:0] rdata
);

   logic [FEAT_CNT-1:0][W-1:0] feat_q;
   logic [W-1:0] level;
   logic         wr_hit;

   assign wr_hit = sel & we;

   for (genvar f = 0; f < FEAT_CNT; f++) begin : g_feat
      logic feat_wr;
      assign feat_wr = wr_hit && (4'(reg_idx) == 4'(f));
      pinctl_feat_reg #(.W(W), .KEEP(KEEP)) u_feat (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (feat_wr),
         .cmd   (wdata),
         .q     (feat_q[f])
      );
   end

   assign drv_lvl = feat_q[int'(REG_DRV_LVL)];
   assign drv_en  = feat_q[int'(REG_DRV_EN)];
   assign in_en   = feat_q[int'(REG_IN_EN)];
   assign oalt1   = feat_q[int'(REG_OALT1)];
   assign oalt2   = feat_q[int'(REG_OALT2)];
   assign ialt1   = feat_q[int'(REG_IALT1)];

   pinctl_edge_det #(.W(W), .SYNC_STAGES(SYNC_STAGES), .KEEP(KEEP)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_in   (pad_in),
      .in_en    (in_en),
      .clr_rise (wr_hit && (reg_idx == REG_RISE)),
      .clr_fall (wr_hit && (reg_idx == REG_FALL)),
      .clr_mask (wdata[W-1:0]),
      .level    (level),
      .rise_sts (rise_sts),
      .fall_sts (fall_sts)
   );

   always_comb begin
      rdata = '0;
      if (sel) begin
         case (reg_idx)
            REG_LEVEL: rdata[W-1:0] = level;
            REG_RISE:  rdata[W-1:0] = rise_sts;
            REG_FALL:  rdata[W-1:0] = fall_sts;
            default: begin
               for (int f = 0; f < FEAT_CNT; f++) begin
                  if (4'(reg_idx) == 4'(f)) rdata[W-1:0] = feat_q[f];
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/pinctl_setclr.sv
// Multi-bank pin controller with set/clear feature registers.
module pinctl_setclr
   import pinctl_pkg::*;
#(
   parameter int PINS_PER_BANK = 16,
   parameter int NBANK         = 2,
   parameter int ADDR_W        = 8,
   parameter int BANK_LSB      = 7,
   parameter int SYNC_STAGES   = 2,
   parameter logic [NBANK*PINS_PER_BANK-1:0] RSVD_MASK = 32'hE080_0000
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ADDR_W-1:0]                bus_addr,
   input  logic                             bus_we,
   input  logic [2*PINS_PER_BANK-1:0]       bus_wdata,
   output logic [2*PINS_PER_BANK-1:0]       bus_rdata,
   input  logic [NBANK*PINS_PER_BANK-1:0]   pad_in,
   output logic [NBANK*PINS_PER_BANK-1:0]   pad_out,
   output logic [NBANK*PINS_PER_BANK-1:0]   pad_oe,
   output logic [NBANK*PINS_PER_BANK-1:0]   in_buf_en,
   output logic [NBANK*PINS_PER_BANK-1:0]   alt_out1_sel,
   output logic [NBANK*PINS_PER_BANK-1:0]   alt_out2_sel,
   output logic [NBANK*PINS_PER_BANK-1:0]   alt_in1_sel
);

   localparam int NPIN       = NBANK * PINS_PER_BANK;
   localparam int DATA_W     = 2 * PINS_PER_BANK;
   localparam int BSEL_W     = (NBANK > 1) ? $clog2(NBANK) : 1;
   localparam int REG_ADDR_W = BANK_LSB - 2;

   if (NBANK < 2) begin : g_chk_nbank
      $error("pinctl_setclr: NBANK must be at least 2");
   end
   if (BANK_LSB < 6) begin : g_chk_lsb
      $error("pinctl_setclr: BANK_LSB too small for the register words");
   end
   if (ADDR_W < BANK_LSB + BSEL_W) begin : g_chk_addr
      $error("pinctl_setclr: ADDR_W cannot hold the bank select");
   end
   if (PINS_PER_BANK < 1) begin : g_chk_ppb
      $error("pinctl_setclr: PINS_PER_BANK must be positive");
   end

   logic [BANK_LSB-1:0]   offs;
   logic [REG_ADDR_W-1:0] word;
   logic [BSEL_W-1:0]     bsel;
   logic                  hi_ok;
   logic                  reg_hit;
   reg_idx_e              reg_idx;
   logic [NBANK-1:0]      bank_sel;
   logic [NBANK-1:0][DATA_W-1:0] bank_rd;
   logic [NPIN-1:0]       rise_sts_all;
   logic [NPIN-1:0]       fall_sts_all;

   assign offs    = bus_addr[BANK_LSB-1:0];
   assign word    = offs[BANK_LSB-1:2];
   assign bsel    = bus_addr[BANK_LSB +: BSEL_W];
   assign reg_hit = (offs[1:0] == 2'b00) && (word < REG_ADDR_W'(REG_CNT));
   assign reg_idx = reg_idx_e'(word[3:0]);

   if (ADDR_W > BANK_LSB + BSEL_W) begin : g_hi_chk
      assign hi_ok = (bus_addr[ADDR_W-1:BANK_LSB+BSEL_W] == '0);
   end else begin : g_hi_none
      assign hi_ok = 1'b1;
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_sel[b] = hi_ok && reg_hit && (bsel == BSEL_W'(b));

      pinctl_bank #(
         .W           (PINS_PER_BANK),
         .SYNC_STAGES (SYNC_STAGES),
         .KEEP        (~RSVD_MASK[b*PINS_PER_BANK +: PINS_PER_BANK])
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (bank_sel[b]),
         .we       (bus_we),
         .reg_idx  (reg_idx),
         .wdata    (bus_wdata),
         .pad_in   (pad_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .drv_lvl  (pad_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .drv_en   (pad_oe[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .in_en    (in_buf_en[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .oalt1    (alt_out1_sel[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .oalt2    (alt_out2_sel[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .ialt1    (alt_in1_sel[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .rise_sts (rise_sts_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .fall_sts (fall_sts_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .rdata    (bank_rd[b])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NBANK; b++) bus_rdata = bus_rdata | bank_rd[b];
   end

endmodule

// File: rtl/pinctl_chk.sv
// Property checker bound to the pin controller top.
module pinctl_chk #(
   parameter int ADDR_W   = 8,
   parameter int PPB      = 16,
   parameter int NPIN     = 32,
   parameter int BANK_LSB = 7,
   parameter logic [NPIN-1:0] RSVD_MASK = 32'hE080_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [2*PPB-1:0]  bus_wdata,
   input logic [2*PPB-1:0]  bus_rdata,
   input logic [NPIN-1:0]   pad_oe,
   input logic [NPIN-1:0]   in_buf_en,
   input logic [NPIN-1:0]   rise_sts_all,
   input logic [NPIN-1:0]   fall_sts_all
);

   // R6
   rsvd_never_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & RSVD_MASK) == '0));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> ((pad_oe == '0) && (rise_sts_all == '0) && (fall_sts_all == '0)));

   // R4
   feat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_addr[1:0] == 2'b00) && (bus_addr[BANK_LSB-1:2] < 6))
      |-> (bus_rdata[2*PPB-1:PPB] == '0));

   // R3
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == ADDR_W'(4)) && bus_wdata[0] && bus_wdata[PPB])
      |=> !pad_oe[0]);

   // R9
   no_edge_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_buf_en == '0) |=> ((rise_sts_all & ~$past(rise_sts_all)) == '0));

endmodule

bind pinctl_setclr pinctl_chk #(
   .ADDR_W    (ADDR_W),
   .PPB       (PINS_PER_BANK),
   .NPIN      (NBANK*PINS_PER_BANK),
   .BANK_LSB  (BANK_LSB),
   .RSVD_MASK (RSVD_MASK)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_we       (bus_we),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .pad_oe       (pad_oe),
   .in_buf_en    (in_buf_en),
   .rise_sts_all (rise_sts_all),
   .fall_sts_all (fall_sts_all)
);

// File: tb/pinctl_setclr_tb.sv
`timescale 1ns/1ps
module pinctl_setclr_tb;

   localparam logic [31:0] RSVD = 32'hE080_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe, in_buf_en, alt_out1_sel, alt_out2_sel, alt_in1_sel;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pinctl_setclr u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .in_buf_en(in_buf_en),
      .alt_out1_sel(alt_out1_sel), .alt_out2_sel(alt_out2_sel),
      .alt_in1_sel(alt_in1_sel)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_feat [6];
   logic [31:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
   logic [31:0] m_rise = '0, m_fall = '0;

   initial for (int i = 0; i < 6; i++) m_feat[i] = '0;

   function automatic logic [31:0] m_rdata(input logic [7:0] a);
      int idx;
      logic [31:0] src;
      idx = int'(a[5:2]);
      if (a[6] || a[1:0] != 2'b00 || idx > 8) return 32'h0;
      if (idx < 6)       src = m_feat[idx];
      else if (idx == 6) src = m_s2 & m_feat[2] & ~RSVD;
      else if (idx == 7) src = m_rise;
      else               src = m_fall;
      return {16'h0, a[7] ? src[31:16] : src[15:0]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 6; i++) m_feat[i] = '0;
         m_s1 = '0; m_s2 = '0; m_s3 = '0; m_rise = '0; m_fall = '0;
      end else begin
         int idx;
         logic [31:0] sm, cm, rev, fev, rclr, fclr;
         idx  = int'(bus_addr[5:2]);
         rev  =  m_s2 & ~m_s3 & m_feat[2] & ~RSVD;
         fev  = ~m_s2 &  m_s3 & m_feat[2] & ~RSVD;
         rclr = '0; fclr = '0;
         if (bus_we && !bus_addr[6] && bus_addr[1:0] == 2'b00) begin
            sm = bus_addr[7] ? {bus_wdata[15:0], 16'h0} : {16'h0, bus_wdata[15:0]};
            cm = bus_addr[7] ? {bus_wdata[31:16], 16'h0} : {16'h0, bus_wdata[31:16]};
            if (idx < 6) m_feat[idx] = ((m_feat[idx] | sm) & ~cm) & ~RSVD;
            else if (idx == 7) rclr = sm;
            else if (idx == 8) fclr = sm;
         end
         m_rise = (m_rise & ~rclr) | rev;
         m_fall = (m_fall & ~fclr) | fev;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = pad_in;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R7 pad_out",      pad_out,      m_feat[0]);
         chk("R7 pad_oe",       pad_oe,       m_feat[1]);
         chk("R7 in_buf_en",    in_buf_en,    m_feat[2]);
         chk("R2 alt_out1_sel", alt_out1_sel, m_feat[3]);
         chk("R2 alt_out2_sel", alt_out2_sel, m_feat[4]);
         chk("R2 alt_in1_sel",  alt_in1_sel,  m_feat[5]);
         chk("R4 bus_rdata",    bus_rdata,    m_rdata(bus_addr));
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_we = 1'b0;
      end
   endtask

   initial begin
      #1_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      idle(3);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      rd(8'h04, d); chk("R1 drive-enable after reset", d, 32'h0);
      chk("R1 pad_oe after reset", pad_oe, 32'h0);
      rd(8'h1C, d); chk("R1 rise status after reset", d, 32'h0);

      // R2: set and clear
      wr(8'h04, 32'h0000_00F5);
      rd(8'h04, d); chk("R2 set pins", d, 32'h0000_00F5);
      chk("R2 pad_oe follows", pad_oe, 32'h0000_00F5);
      wr(8'h04, 32'h0005_0000);
      rd(8'h04, d); chk("R2 clear pins 0,2", d, 32'h0000_00F0);

      // R3: clear wins
      wr(8'h04, 32'h0011_0012);
      rd(8'h04, d); chk("R3 clear wins pin4, set pin1", d, 32'h0000_00E2);

      // R5 / R6: second bank, reserved pins
      wr(8'h84, 32'h0000_FFFF);
      rd(8'h84, d); chk("R5 R6 bank1 enable readback", d, 32'h0000_1F7F);
      chk("R5 pad_oe high half", pad_oe, 32'h1F7F_00E2);
      wr(8'h80, 32'h0000_FFFF);
      rd(8'h80, d); chk("R6 reserved pins ignore write", d, 32'h0000_1F7F);
      chk("R6 reserved pad_out zero", pad_out & RSVD, 32'h0);

      // R7: drive level to pad
      wr(8'h00, 32'h0000_0003);
      rd(8'h00, d); chk("R7 drive level readback", d, 32'h0000_0003);
      chk("R7 pad_out low half", pad_out[15:0], 32'h3);

      // R8: level with sync delay and input gating
      wr(8'h08, 32'h0000_000F);
      wr(8'h18, 32'hFFFF_FFFF);            // write to level word has no effect
      @(negedge clk) begin bus_we = 1'b0; pad_in = 32'h0000_0105; end
      rd(8'h18, d); chk("R8 level not yet visible", d, 32'h0);
      rd(8'h18, d); chk("R8 level after two edges", d, 32'h0000_0005);

      // R9: rising status, disabled pin 8 ignored
      rd(8'h1C, d); chk("R9 rise status", d, 32'h0000_0005);
      rd(8'h20, d); chk("R9 fall status empty", d, 32'h0);

      // R10: clear by ones, upper half ignored, no set
      wr(8'h1C, 32'h0004_0001);
      rd(8'h1C, d); chk("R10 clear pin0 only", d, 32'h0000_0004);
      wr(8'h20, 32'h0000_0002);
      rd(8'h20, d); chk("R10 status write never sets", d, 32'h0);

      // R9: falling edge on pin 2
      @(negedge clk) begin bus_we = 1'b0; pad_in = 32'h0000_0101; end
      idle(3);
      rd(8'h20, d); chk("R9 fall status pin2", d, 32'h0000_0004);

      // R11: new rise on pin2 lands with clearing write
      @(negedge clk) begin bus_we = 1'b0; pad_in = 32'h0000_0105; end
      idle(1);
      wr(8'h1C, 32'h0000_0004);
      rd(8'h1C, d); chk("R11 edge kept over clear", d, 32'h0000_0004);

      // random traffic against the model
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         bus_we    = ($urandom % 3) != 0;
         bus_addr  = {1'($urandom), 1'(($urandom % 16) == 0), 4'($urandom % 11), 2'(($urandom % 12) == 0)};
         bus_wdata = $urandom;
         if (($urandom % 4) == 0) pad_in = $urandom;
      end

      // R1: reset mid-run
      @(negedge clk) begin bus_we = 1'b0; rst_n = 1'b0; end
      idle(2);
      chk("R1 pad_oe during reset", pad_oe, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      rd(8'h88, d); chk("R1 input enable after reset", d, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule